// File: doc/BRIEF.md
# Pre-reset handshake sequencer

Before a reset is applied, this block runs a fence-and-drain handshake with up to nine peripheral channels. It raises a request to every channel that takes part, waits until each of them acknowledges, and then gives a one-cycle reset pulse. A privileged register decides which channels may take part. A channel whose peripheral is already held in reset is left out. The two interconnect channels also depend on which reset domains are being reset together.

Software reaches the block through a small register port. The enable register sits at offset 0x10. A write to the go register at 0x14 starts a handshake without any reset pulse. The status register at 0x18 shows which channels acknowledged and whether the wait ever timed out. If an acknowledge never comes, a timeout counter lets the reset go ahead anyway.

Top module: `rst_hs_seq`

## Requirements
- R1: After a cold reset, offset 0x10 reads 0xFFFFFFFB. The writable bits are 0, 2, 3, 9, 10, 11, 12, 16 and 17. Every other bit always reads 1 and ignores writes, so writing 0 reads back 0xFFFCE1F2.
- R2: An access with `reg_priv` low reads zero and does not change the enable register.
- R3: The enable register keeps its value through a warm reset and returns to 0xFFFFFFFB only on a cold reset. A warm reset clears the status register.
- R4: One clock after `rst_req` is seen in idle, all participating channels raise `hs_req` together. Channel index k maps to enable bit 0, 2, 3, 9, 10, 11, 12, 16, 17 for k = 0..8. The requests stay constant while the sequencer waits.
- R5: A channel whose enable bit is 0, or whose `in_rst` bit is 1, gets no request and is not waited for.
- R6: Channel 7 takes part only when `rst_ic`=1 and `rst_dbg`=0. Channel 8 takes part only when `rst_dbg`=1 and `rst_ic`=0.
- R7: `rst_out` is high for exactly one cycle. That cycle follows the first cycle in which every participating acknowledge is high. The requests stay up during the pulse and drop to zero in the next cycle.
- R8: When no channel takes part, the pulse still comes two cycles after the request, and no `hs_req` bit rises.
- R9: If the acknowledges are not complete after TMO_CYC cycles of waiting, the reset fires anyway. Status bit 31 is then set, and it stays set until a cold or warm reset.
- R10: Writing 1 to bit 0 of offset 0x14 runs the same gated handshake but produces no `rst_out` pulse. Writing 0 to that bit does nothing.
- R11: A hardware request and a software go in the same idle cycle start a single sequence, which ends with a reset pulse. Requests that arrive while a sequence is running are ignored.
- R12: Status bits 8:0 hold the channels that both took part and acknowledged when the wait ended. They are cleared when a new sequence starts and read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, clears everything |
| warm_rst_n | input | 1 | Warm reset, active low, keeps the enable register |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_priv | input | 1 | Access is privileged |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| rst_req | input | 1 | Hardware reset request |
| rst_ic | input | 1 | Interconnect domain is part of this reset |
| rst_dbg | input | 1 | A debug domain is part of this reset |
| in_rst | input | 9 | Per-channel peripheral already in reset |
| hs_req | output | 9 | Per-channel handshake request |
| hs_ack | input | 9 | Per-channel handshake acknowledge |
| rst_out | output | 1 | Reset pulse |

## Verification
A hardware reset request and a software go write can reach the idle sequencer in the same cycle. The bench drives both on one falling edge. It then expects one sequence with the hardware gating and exactly one reset pulse, followed by an empty scoreboard queue. The bench also repeats `rst_req` while the sequencer is waiting. The monitor fails any extra pulse it finds with no queued expectation.

// File: rtl/rst_hs_seq.sv
module rst_hs_seq #(
  parameter int ADDR_W  = 8,
  parameter int TMO_CYC = 16
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic              reg_priv,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rst_req,
  input  logic              rst_ic,
  input  logic              rst_dbg,
  input  logic [8:0]        in_rst,
  output logic [8:0]        hs_req,
  input  logic [8:0]        hs_ack,
  output logic              rst_out
);
  localparam int NCH = 9;
  localparam int TW  = $clog2(TMO_CYC + 1);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_GO  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'('h18);
  localparam logic [31:0]       RO_ONES = 32'hFFFC_E1F2;
  localparam logic [NCH-1:0]    EN_RST  = 9'h1FD;
  localparam int POS [NCH] = '{0, 2, 3, 9, 10, 11, 12, 16, 17};

  typedef enum logic [1:0] {IDLE, WAIT, FIRE} st_t;

  st_t            st;
  logic [NCH-1:0] en_q, wr_bits, part, part_q, done_q, dom_ok;
  logic [TW-1:0]  cnt;
  logic           is_hw, tmo_q;
  logic [31:0]    en_word;

  wire acc     = reg_en & reg_priv;
  wire wr      = acc & reg_we;
  wire sw_go   = wr && (reg_addr == A_GO) && reg_wdata[0];
  wire start   = (st == IDLE) && (rst_req || sw_go);
  wire all_ack = (hs_ack & part_q) == part_q;
  wire tmo_hit = cnt == TW'(TMO_CYC - 1);

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  genvar g;
  for (g = 0; g < NCH; g++) begin : g_map
    assign wr_bits[g] = reg_wdata[POS[g]];
  end

  always_comb begin
    en_word = RO_ONES;
    for (int i = 0; i < NCH; i++) en_word[POS[i]] = en_q[i];
  end

  assign dom_ok  = {rst_dbg & ~rst_ic, rst_ic & ~rst_dbg, 7'h7F};
  assign part    = en_q & ~in_rst & dom_ok;
  assign hs_req  = (st == IDLE) ? '0 : part_q;
  assign rst_out = (st == FIRE) && is_hw;

  always_comb begin
    reg_rdata = '0;
    if (acc && !reg_we) begin
      if (reg_addr == A_EN)  reg_rdata = en_word;
      if (reg_addr == A_STS) reg_rdata = {tmo_q, 22'd0, done_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n)                  en_q <= EN_RST;
    else if (wr && reg_addr == A_EN)  en_q <= wr_bits;
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n || !warm_rst_n) begin
      st     <= IDLE;
      part_q <= '0;
      done_q <= '0;
      cnt    <= '0;
      is_hw  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st     <= WAIT;
          part_q <= part;
          is_hw  <= rst_req;
          cnt    <= '0;
          done_q <= '0;
        end
        WAIT: begin
          if (all_ack || tmo_hit) begin
            st     <= FIRE;
            done_q <= part_q & hs_ack;
            if (!all_ack) tmo_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st     <= IDLE;
          part_q <= '0;
        end
      endcase
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (st == WAIT) |=> hs_req == $past(hs_req));
  p_skip_r5: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (st == IDLE) |=> (hs_req & ($past(in_rst) | ~$past(en_q))) == '0);
  p_excl_r6: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    !(hs_req[7] && hs_req[8]));
  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    rst_out |=> !rst_out);
  p_acked_r7: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    rst_out |-> ($past((hs_ack & hs_req) == hs_req) || tmo_q));
  p_req_drop_r7: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (st == FIRE) |=> hs_req == '0);
  p_unpriv_r2: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (reg_en && reg_we && !reg_priv) |=> $stable(en_q));
  p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    tmo_q |=> tmo_q);
endmodule

// File: tb/rst_hs_seq_tb.sv
module rst_hs_seq_tb;
  localparam int CLK_NS = 10;

  logic        clk = 0, cold_rst_n = 0, warm_rst_n = 1;
  logic        reg_en = 0, reg_we = 0, reg_priv = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        rst_req = 0, rst_ic = 0, rst_dbg = 0, rst_out;
  logic [8:0]  in_rst = 0, hs_req, hs_ack, ack_mask = 9'h1FF;

  int n_vec = 0, n_bad = 0, n_pulse = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_NS/2) clk = ~clk;
  assign hs_ack = hs_req & ack_mask;

  rst_hs_seq u_dut (.clk, .cold_rst_n, .warm_rst_n, .reg_en, .reg_we, .reg_priv,
    .reg_addr, .reg_wdata, .reg_rdata, .rst_req, .rst_ic, .rst_dbg, .in_rst,
    .hs_req, .hs_ack, .rst_out);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_out) begin
    n_pulse++;
    n_vec++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R11 unexpected reset pulse act=%h exp=none", hs_req);
    end else begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (hs_req !== e) begin
        n_bad++;
        $display("FAIL %s reqs at pulse act=%h exp=%h", t, hs_req, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, logic p, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_priv = p; reg_addr = a;
    #1 check(tag, reg_rdata, exp);
    reg_en = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic p);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_priv = p; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic hw_go(logic ic, logic dbg, logic [8:0] exp, string tag);
    @(negedge clk);
    rst_req = 1; rst_ic = ic; rst_dbg = dbg;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rst_req = 0;
    check(tag, hs_req, exp);
  endtask

  task automatic do_rst(bit cold);
    @(negedge clk);
    if (cold) cold_rst_n = 0; else warm_rst_n = 0;
    idle(3);
    cold_rst_n = 1; warm_rst_n = 1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    int p0;
    do_rst(1);
    rd(8'h10, 1, 32'hFFFF_FFFB, "R1 enable reset value");
    rd(8'h18, 1, 32'h0, "R12 status after reset");
    rd(8'h10, 0, 32'h0, "R2 unprivileged read");
    wr(8'h10, 32'h0, 0);
    rd(8'h10, 1, 32'hFFFF_FFFB, "R2 unprivileged write ignored");
    wr(8'h10, 32'h0, 1);
    rd(8'h10, 1, 32'hFFFC_E1F2, "R1 reserved bits fixed");
    wr(8'h10, 32'hFFFF_FFFF, 1);
    rd(8'h10, 1, 32'hFFFF_FFFF, "R1 all writable set");

    hw_go(0, 0, 9'h07F, "R4 no domain");
    idle(2);
    check("R7 reqs dropped", hs_req, 0);
    rd(8'h18, 1, 32'h7F, "R12 done mask");
    hw_go(1, 0, 9'h0FF, "R6 interconnect only"); idle(3);
    hw_go(0, 1, 9'h17F, "R6 debug only"); idle(3);
    hw_go(1, 1, 9'h07F, "R6 both domains"); idle(3);

    wr(8'h10, 32'hFFFF_FBFE, 1);
    in_rst = 9'h004;
    hw_go(1, 0, 9'h0EA, "R5 disabled and in-reset skipped"); idle(3);
    rd(8'h18, 1, 32'hEA, "R12 done after skip");
    in_rst = 9'h1FF;
    hw_go(0, 0, 9'h000, "R8 nobody participates"); idle(3);
    in_rst = 9'h000;

    ack_mask = 9'h1FD;
    hw_go(0, 0, 9'h06E, "R7 waits for ack");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 no pulse before ack", rst_out, 0);
    end
    ack_mask = 9'h1FF;
    @(negedge clk);
    check("R7 pulse after last ack", rst_out, 1);
    @(negedge clk);
    check("R7 pulse one cycle", rst_out, 0);
    check("R7 reqs dropped after pulse", hs_req, 0);

    ack_mask = 9'h1FD;
    hw_go(0, 0, 9'h06E, "R9 timeout run");
    idle(25);
    ack_mask = 9'h1FF;
    rd(8'h18, 1, 32'h8000_006C, "R9 timeout flag and partial done");
    hw_go(0, 0, 9'h06E, "R9 after timeout"); idle(3);
    rd(8'h18, 1, 32'h8000_006E, "R9 timeout sticky");

    do_rst(0);
    rd(8'h10, 1, 32'hFFFF_FBFE, "R3 enable kept over warm reset");
    rd(8'h18, 1, 32'h0, "R3 status cleared by warm reset");
    do_rst(1);
    rd(8'h10, 1, 32'hFFFF_FFFB, "R3 cold reset restores");

    rst_ic = 0; rst_dbg = 0;
    p0 = n_pulse;
    wr(8'h14, 32'h2, 1);
    check("R10 go bit clear does nothing", hs_req, 0);
    wr(8'h14, 32'h1, 1);
    check("R10 software handshake gated", hs_req, 9'h07D);
    idle(4);
    check("R10 no reset pulse", n_pulse - p0, 0);
    rd(8'h18, 1, 32'h7D, "R10 software done mask");

    p0 = n_pulse;
    @(negedge clk);
    rst_req = 1;
    reg_en = 1; reg_we = 1; reg_priv = 1; reg_addr = 8'h14; reg_wdata = 1;
    exp_q.push_back(9'h07D); tag_q.push_back("R11 collision");
    @(negedge clk);
    reg_en = 0; reg_we = 0;
    check("R11 one sequence started", hs_req, 9'h07D);
    @(negedge clk);
    rst_req = 0;
    idle(4);
    check("R11 exactly one pulse", n_pulse - p0, 1);
    check("R11 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule